// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the target of procedure returns for an in-order processor front end. The call side pushes a predicted return address with a one-cycle strobe. The decode side presents the fields of each decoded instruction. When the fields match the single return form that the block recognises, it pops the newest stored address and presents it, with a valid bit, in the following cycle.

The recognised return form is a load whose destination is the program counter (register 15). It must use the stack pointer (register 13) as the base and a post-indexed, added immediate offset of exactly 4. A load to the program counter in any other form passes through without touching the stack. The storage holds four word-aligned addresses and drops the oldest one on overflow. A flush input empties it. A resolve port reports the real target of each return, and the block counts hits and misses against its most recent valid prediction.

Top module: `retStackPredictor`

## Requirements
- R1: A return is recognised only when decValid=1, decLoad=1, decDest=15, decBase=13, decPostIdx=1, decImmOff=1, decUp=1 and decImm=4. Any other combination neither pops the stack nor raises predValid.
- R2: One cycle after a recognised return with a non-empty stack, predValid is 1 for one cycle and predTarget is the newest address pushed and not yet popped (last in, first out).
- R3: The stack holds at most 4 entries. A push onto a full stack discards the oldest entry and keeps the newest 4.
- R4: A recognised return on an empty stack gives predValid=0 in the next cycle and leaves the stack unchanged.
- R5: A push and a recognised return in the same cycle on a non-empty stack predict the old top entry and replace it with the pushed address, so the depth does not change. On an empty stack the pop is invalid and the push proceeds as a normal push.
- R6: flushIn empties the stack. It overrides a push and a return in the same cycle, and that return gives predValid=0.
- R7: On resolveValid, hitCount increments if a valid prediction has been made since reset and resolveTarget equals the most recent valid predTarget. Otherwise missCount increments. Both counters are CNT_W bits wide and wrap.
- R8: Stored addresses are word aligned. Bits [1:0] of pushAddr are stored as 0, so predTarget[1:0] is always 0.
- R9: After reset the stack is empty, predValid is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| flushIn | input | 1 | Empties the stack; overrides push and pop |
| pushValid | input | 1 | Push strobe from the call side |
| pushAddr | input | ADDR_W | Return address to push |
| decValid | input | 1 | Decode fields are valid this cycle |
| decLoad | input | 1 | Instruction is a load |
| decDest | input | 4 | Destination register number |
| decBase | input | 4 | Base register number |
| decPostIdx | input | 1 | Post-indexed addressing |
| decImmOff | input | 1 | Offset is an immediate |
| decUp | input | 1 | Offset is added (1) or subtracted (0) |
| decImm | input | IMM_W | Immediate offset magnitude |
| resolveValid | input | 1 | Actual return target is reported |
| resolveTarget | input | ADDR_W | Actual return target |
| predValid | output | 1 | Prediction valid, one cycle after a return |
| predTarget | output | ADDR_W | Predicted return target |
| hitCount | output | CNT_W | Correct predictions |
| missCount | output | CNT_W | Incorrect or absent predictions |

## Verification
A corrupted depth or top pointer shows at the ports on the next recognised return. The block then returns the wrong entry, raises predValid on an empty stack, or drops a valid prediction, one cycle after the decode. Overflow faults only show after a run of pops drains the surviving entries, so the bench pops each filled stack until it is empty. A wrong comparison in the resolve path shows up in the hit and miss counters one cycle after the resolve strobe, and the bench compares both counters every cycle.

// File: rtl/rasPkg.sv
package rasPkg;
  localparam int RAS_DEPTH = 4;   // must be a power of two
  localparam int RAS_IDX_W = $clog2(RAS_DEPTH);
  localparam int RAS_ADDR_W = 32;
  localparam int RAS_IMM_W = 12;
  localparam int RAS_CNT_W = 16;
  localparam logic [3:0] PC_REG = 4'd15;
  localparam logic [3:0] SP_REG = 4'd13;
  localparam int RET_STEP = 4;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic                 wrEn;
    logic [RAS_IDX_W-1:0] wrIdx;
    logic                 popOk;
    logic [RAS_IDX_W-1:0] rdIdx;
  } rasCtlT;
endpackage

// File: rtl/rasRetDetect.sv
module rasRetDetect
  import rasPkg::*;
#(
  parameter int IMM_W = RAS_IMM_W
) (
  input  logic             decValid,
  input  logic             decLoad,
  input  logic [3:0]       decDest,
  input  logic [3:0]       decBase,
  input  logic             decPostIdx,
  input  logic             decImmOff,
  input  logic             decUp,
  input  logic [IMM_W-1:0] decImm,
  output logic             isRet
);
  localparam logic [IMM_W-1:0] STEP = IMM_W'(RET_STEP);

  // R1: single exact form, every field must match
  always_comb begin
    isRet = decValid && decLoad && (decDest == PC_REG) && (decBase == SP_REG)
         && decPostIdx && decImmOff && decUp && (decImm == STEP);
  end
endmodule

// File: rtl/rasCtl.sv
module rasCtl
  import rasPkg::*;
#(
  parameter int DEPTH = RAS_DEPTH,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flushIn,
  input  logic               pushValid,
  input  logic               isRet,
  output rasCtlT             ctl,
  output logic [DEPTH_W-1:0] depth
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(DEPTH);

  logic [IDX_W-1:0] topPtr;
  logic pushReq, popReq, popOk;

  assign pushReq = pushValid && !flushIn;
  assign popReq  = isRet && !flushIn;
  assign popOk   = popReq && (depth != '0);

  always_comb begin
    ctl       = '0;
    ctl.popOk = popOk;
    ctl.rdIdx = topPtr;
    if (pushReq) begin
      ctl.wrEn  = 1'b1;
      ctl.wrIdx = popOk ? topPtr : topPtr + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topPtr <= '0;
      depth  <= '0;
    end else if (flushIn) begin
      topPtr <= '0;
      depth  <= '0;
    end else if (pushReq && popOk) begin
      topPtr <= topPtr;            // replace in place
    end else if (pushReq) begin
      topPtr <= topPtr + IDX_W'(1);  // wraps over the oldest slot when full
      if (depth != FULL) depth <= depth + DEPTH_W'(1);
    end else if (popOk) begin
      topPtr <= topPtr - IDX_W'(1);
      depth  <= depth - DEPTH_W'(1);
    end
  end

  // R3: depth never passes the capacity
  always @(posedge clk) if (rstN) a_r3_depth_bound: assert (depth <= FULL);

  // R6: a flush leaves the stack empty
  a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |=> depth == '0);

  // R5: push with a valid pop keeps the depth
  a_r5_replace_depth: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && isRet && !flushIn && depth != '0) |=> depth == $past(depth));
endmodule

// File: rtl/rasData.sv
module rasData
  import rasPkg::*;
#(
  parameter int DEPTH = RAS_DEPTH,
  parameter int ADDR_W = RAS_ADDR_W,
  parameter int CNT_W = RAS_CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  rasCtlT            ctl,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic              resolveValid,
  input  logic [ADDR_W-1:0] resolveTarget,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] entries [DEPTH];
  logic [ADDR_W-1:0] lastTarget;
  logic              lastValid;

  // R8: low two bits dropped on write
  always_ff @(posedge clk) begin
    if (ctl.wrEn) entries[ctl.wrIdx] <= pushAddr & ALIGN_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predValid  <= 1'b0;
      predTarget <= '0;
      lastValid  <= 1'b0;
      lastTarget <= '0;
    end else begin
      predValid <= ctl.popOk;
      if (ctl.popOk) begin
        predTarget <= entries[ctl.rdIdx];
        lastTarget <= entries[ctl.rdIdx];
        lastValid  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else if (resolveValid) begin
      if (lastValid && resolveTarget == lastTarget) hitCount <= hitCount + CNT_W'(1);
      else missCount <= missCount + CNT_W'(1);
    end
  end

  logic [CNT_W-1:0] tallySum;
  assign tallySum = hitCount + missCount;

  // R7: exactly one counter moves per resolve
  a_r7_one_tally: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid |=> tallySum == $past(tallySum) + CNT_W'(1));
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resolveValid |=> $stable(hitCount) && $stable(missCount));

  // R8: predictions are word aligned
  a_r8_aligned: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> predTarget[1:0] == 2'b00);
endmodule

// File: rtl/retStackPredictor.sv
module retStackPredictor
  import rasPkg::*;
#(
  parameter int DEPTH = RAS_DEPTH,
  parameter int ADDR_W = RAS_ADDR_W,
  parameter int IMM_W = RAS_IMM_W,
  parameter int CNT_W = RAS_CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushIn,
  input  logic              pushValid,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic              decValid,
  input  logic              decLoad,
  input  logic [3:0]        decDest,
  input  logic [3:0]        decBase,
  input  logic              decPostIdx,
  input  logic              decImmOff,
  input  logic              decUp,
  input  logic [IMM_W-1:0]  decImm,
  input  logic              resolveValid,
  input  logic [ADDR_W-1:0] resolveTarget,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  localparam int DEPTH_W = $clog2(DEPTH + 1);

  logic               isRet;
  rasCtlT             ctl;
  logic [DEPTH_W-1:0] depth;

  rasRetDetect #(.IMM_W(IMM_W)) i_detect (
    .decValid(decValid), .decLoad(decLoad), .decDest(decDest), .decBase(decBase),
    .decPostIdx(decPostIdx), .decImmOff(decImmOff), .decUp(decUp), .decImm(decImm),
    .isRet(isRet)
  );

  rasCtl #(.DEPTH(DEPTH)) i_ctl (
    .clk(clk), .rstN(rstN), .flushIn(flushIn), .pushValid(pushValid),
    .isRet(isRet), .ctl(ctl), .depth(depth)
  );

  rasData #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pushAddr(pushAddr),
    .resolveValid(resolveValid), .resolveTarget(resolveTarget),
    .predValid(predValid), .predTarget(predTarget),
    .hitCount(hitCount), .missCount(missCount)
  );

  // R4: a return on an empty stack yields no prediction
  a_r4_empty_no_pred: assert property (@(posedge clk) disable iff (!rstN)
    (isRet && depth == '0) |=> !predValid);

  // R2: a return on a non-empty stack always predicts
  a_r2_pred_follows: assert property (@(posedge clk) disable iff (!rstN)
    (isRet && !flushIn && depth != '0) |=> predValid);
endmodule

// File: tb/test_retStackPredictor.sv
module test_retStackPredictor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushIn = 1'b0, pushValid = 1'b0;
  logic [31:0] pushAddr = '0;
  logic        decValid = 1'b0, decLoad = 1'b0, decPostIdx = 1'b0, decImmOff = 1'b0, decUp = 1'b0;
  logic [3:0]  decDest = '0, decBase = '0;
  logic [11:0] decImm = '0;
  logic        resolveValid = 1'b0;
  logic [31:0] resolveTarget = '0;
  logic        predValid;
  logic [31:0] predTarget;
  logic [15:0] hitCount, missCount;

  always #5 clk = ~clk;

  retStackPredictor i_retStackPredictor (.*);

  typedef struct { bit v; logic [31:0] t; int unsigned h; int unsigned m; string req; } expT;
  expT expQ[$];
  logic [31:0] mdl[$];
  bit mLastValid = 0;
  logic [31:0] mLastTarget = '0;
  int unsigned mHit = 0, mMiss = 0;
  int nTests = 0, nFail = 0;

  function automatic bit modelIsRet();
    return decValid && decLoad && decDest == 4'd15 && decBase == 4'd13 &&
           decPostIdx && decImmOff && decUp && decImm == 12'd4;
  endfunction

  task automatic setCanon();
    decLoad = 1; decDest = 15; decBase = 13; decPostIdx = 1; decImmOff = 1; decUp = 1; decImm = 4;
  endtask

  // Driver: one cycle of stimulus plus the expected result of that edge
  task automatic step(bit push, logic [31:0] addr, bit dec, bit flush,
                      bit res, logic [31:0] resAddr, string req);
    expT e;
    bit ret;
    @(negedge clk);
    pushValid = push; pushAddr = addr; decValid = dec; flushIn = flush;
    resolveValid = res; resolveTarget = resAddr;
    ret = modelIsRet();
    if (res) begin
      if (mLastValid && resAddr == mLastTarget) mHit++; else mMiss++;
    end
    e.v = 0; e.t = '0; e.req = req;
    if (flush) mdl.delete();
    else if (ret && mdl.size() > 0) begin
      e.v = 1; e.t = mdl[$];
      if (push) mdl[$] = addr & ~32'd3;
      else void'(mdl.pop_back());
    end else if (push) begin
      mdl.push_back(addr & ~32'd3);
      if (mdl.size() > 4) void'(mdl.pop_front());
    end
    if (e.v) begin mLastValid = 1; mLastTarget = e.t; end
    e.h = mHit; e.m = mMiss;
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    pushValid = 0; decValid = 0; flushIn = 0; resolveValid = 0;
    setCanon();
  endtask

  // Monitor: compare each edge's result against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        nTests++;
        if (predValid !== e.v || (e.v && predTarget !== e.t) ||
            hitCount !== 16'(e.h) || missCount !== 16'(e.m)) begin
          nFail++;
          $display("FAIL %s: got valid=%0b target=%h hit=%0d miss=%0d, expected valid=%0b target=%h hit=%0d miss=%0d",
                   e.req, predValid, predTarget, hitCount, missCount, e.v, e.t, e.h, e.m);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    setCanon();
    repeat (3) @(posedge clk);
    #3 rstN = 1;
    // R9: reset state
    @(negedge clk);
    nTests++;
    if (predValid !== 0 || hitCount !== 0 || missCount !== 0) begin
      nFail++;
      $display("FAIL R9: got valid=%0b hit=%0d miss=%0d, expected 0 0 0", predValid, hitCount, missCount);
    end
    // R7: resolve before any prediction is a miss
    step(0, 0, 0, 0, 1, 32'h100, "R7 no prediction");
    // R4: pop on empty, then the stack still works
    step(0, 0, 1, 0, 0, 0, "R4 empty pop");
    step(1, 32'h0000_1000, 0, 0, 0, 0, "R4 push");
    step(0, 0, 1, 0, 0, 0, "R4 pop after empty pop");
    step(0, 0, 1, 0, 0, 0, "R4 empty again");
    // R7: hit and miss against the last prediction
    step(0, 0, 0, 0, 1, 32'h0000_1000, "R7 hit");
    step(0, 0, 0, 0, 1, 32'h0000_1004, "R7 miss");
    // R2: last-in first-out order
    step(1, 32'h0000_2000, 0, 0, 0, 0, "R2 push");
    step(1, 32'h0000_3000, 0, 0, 0, 0, "R2 push");
    step(1, 32'h0000_4000, 0, 0, 0, 0, "R2 push");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, "R2 pop order");
    // R1: near-miss forms do not pop
    step(1, 32'h0000_5000, 0, 0, 0, 0, "R1 push");
    for (int k = 0; k < 8; k++) begin
      idle();
      case (k)
        0: decBase = 12;
        1: decImm = 8;
        2: decPostIdx = 0;
        3: decImmOff = 0;
        4: decUp = 0;
        5: decDest = 14;
        6: decLoad = 0;
        default: ;
      endcase
      step(0, 0, (k != 7), 0, 0, 0, "R1 non-return form");
      idle();
    end
    step(0, 0, 1, 0, 0, 0, "R1 canonical return");
    step(0, 0, 1, 0, 0, 0, "R1 stack drained");
    // R3: overflow keeps the newest four
    for (int i = 0; i < 6; i++) step(1, 32'h0001_0000 + 32'(i) * 16, 0, 0, 0, 0, "R3 push");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, "R3 pop after overflow");
    // R5: push and pop together replace the top
    step(1, 32'h0000_A000, 0, 0, 0, 0, "R5 push");
    step(1, 32'h0000_B000, 0, 0, 0, 0, "R5 push");
    step(1, 32'h0000_C000, 1, 0, 1, 32'h0000_B000, "R5 replace");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, "R5 pop after replace");
    step(1, 32'h0000_D000, 1, 0, 0, 0, "R5 push+pop empty");
    step(0, 0, 1, 0, 1, 32'h0000_B000, "R5 pushed on empty");
    // R6: flush empties and overrides
    step(1, 32'h0000_E000, 0, 0, 0, 0, "R6 push");
    step(1, 32'h0000_F000, 0, 0, 0, 0, "R6 push");
    step(0, 0, 0, 1, 0, 0, "R6 flush");
    step(0, 0, 1, 0, 0, 0, "R6 pop after flush");
    step(1, 32'h0000_E100, 0, 0, 0, 0, "R6 push");
    step(1, 32'h0000_E200, 1, 1, 0, 0, "R6 flush overrides");
    step(0, 0, 1, 0, 0, 0, "R6 empty after override");
    // R8: alignment of stored addresses
    step(1, 32'h0000_1003, 0, 0, 0, 0, "R8 push unaligned");
    step(1, 32'h0000_2006, 0, 0, 0, 0, "R8 push unaligned");
    step(0, 0, 1, 0, 0, 0, "R8 aligned pop");
    step(0, 0, 1, 0, 1, 32'h0000_2004, "R8 aligned pop");
    idle();
    repeat (3) @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule